// File: doc/BRIEF.md
# PS/2 Host Controller with Wishbone Registers

This block lets a processor on a Wishbone bus exchange single bytes with a PS/2 keyboard or mouse. The processor side sees two registers behind a one-bit address and an interrupt line. The device side drives the shared clock and data wires open-drain style. Each wire has an input pin and an output-enable pin, and an asserted enable pulls the wire low.

To send a byte, software writes it into the data register, which only stages it. Software then sets the strobe bit in the control register. The controller holds the clock wire low for a programmable inhibit time, pulls data low as the start bit, releases the clock and then serves the device-generated clock. It shifts out eight data bits, a generated odd-parity bit and a released stop bit, and waits for the device's acknowledge clock.

In the other direction, the controller synchronises and filters the device clock. It samples the data wire on every filtered falling edge and assembles the frame. A byte with correct odd parity and a high stop bit replaces the readable data register and raises the interrupt for a guaranteed minimum width. A frame that stops receiving clock edges is abandoned by a stall timer.

Top module: `ps2h_top`

## Requirements
- R1: A write to address 0 only stages a byte. No clock inhibit and no data drive appear on the PS/2 wires until bit 1 (strobe) of the control register at address 1 is written as 1.
- R2: The strobe request is visible as control read bit 1 while it waits, for example behind a reception in progress. It clears itself in the cycle the transmission begins.
- R3: Control read bit 0 (busy) is 1 while a strobe waits or a frame is sent or received, and 0 otherwise. Transmission and reception never run at the same time.
- R4: A transmission first holds the clock wire low for at least INHIBIT_CYC system cycles. It then has the data wire low (start bit 0) when the clock wire is released.
- R5: After the start bit, the host presents the eight data bits least significant first, then an odd-parity bit (data plus parity holds an odd count of ones), then a released stop bit of 1. Each bit changes after a falling device-clock edge. The frame ends on the eleventh falling edge, which is the device's acknowledge.
- R6: Received frames are sampled on falling edges of the synchronised and filtered clock. A frame is a start bit 0, eight data bits least significant first, an odd-parity bit and a stop bit 1.
- R7: A received frame with correct parity and stop bit replaces the byte read at address 0 and raises irq_o.
- R8: A received frame with wrong parity raises no interrupt and leaves the byte read at address 0 unchanged.
- R9: Once raised, irq_o stays high for IRQ_HOLD system cycles, which is never fewer than 13.
- R10: A frame that sees no falling clock edge for TIMEOUT_CYC cycles is aborted. Busy clears, both wires are released, and the next frame is received normally.
- R11: After reset, irq_o and both output enables are 0 and both registers read 0.
- R12: Every bus cycle is answered by a single-cycle wb_ack_o. Read data is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Slave select strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 1 | 0 selects the data register, 1 selects the control register |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data |
| wb_ack_o | output | 1 | Transfer acknowledge |
| irq_o | output | 1 | Received-byte interrupt |
| ps2_clk_i | input | 1 | Level of the PS/2 clock wire |
| ps2_clk_oe_o | output | 1 | Pull the clock wire low when 1 |
| ps2_dat_i | input | 1 | Level of the PS/2 data wire |
| ps2_dat_oe_o | output | 1 | Pull the data wire low when 1 |

## Verification
A wrong transmitter state shows within one device clock period as a misplaced bit on the data wire or a wrong inhibit length. The device model catches either while it reassembles the frame. A receiver that shifts too few or too many bits, or checks parity wrongly, shows a few cycles after the eleventh edge as a wrong read-back byte, a missing interrupt or a spurious one. A lost idle state shows as busy stuck high after the stall window, or as the following good frame going unreceived.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;
   localparam int unsigned BYTE_W  = 8;
   // bits clocked after the start bit: data, parity, stop
   localparam int unsigned FRAME_W = BYTE_W + 2;
   localparam int unsigned IRQ_MIN = 13;

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_INHIBIT,
      TX_RELEASE,
      TX_BITS,
      TX_ACK
   } tx_state_e;

   typedef enum logic {
      RX_IDLE,
      RX_FRAME
   } rx_state_e;

   // bit that makes the count of ones across data and parity odd
   function automatic logic odd_fill(input byte_t d);
      return ~(^d);
   endfunction
endpackage

// File: rtl/ps2h_line_filter.sv
module ps2h_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic line_clk_i,
   input  logic line_dat_i,
   output logic clk_filt_o,
   output logic dat_sync_o,
   output logic fall_o
);
   logic [SYNC_STAGES-1:0] clk_sync_q;
   logic [SYNC_STAGES-1:0] dat_sync_q;
   logic clk_s;
   logic filt_q;
   logic filt_d;
   logic fall_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         clk_sync_q <= '1;
         dat_sync_q <= '1;
      end else begin
         clk_sync_q <= {clk_sync_q[SYNC_STAGES-2:0], line_clk_i};
         dat_sync_q <= {dat_sync_q[SYNC_STAGES-2:0], line_dat_i};
      end
   end

   assign clk_s = clk_sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN <= 1) begin : g_direct
         assign filt_d = clk_s;
      end else begin : g_count
         localparam int unsigned CW = $clog2(FILT_LEN);
         localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk_i) begin
            if (rst_i || (clk_s == filt_q) || (cnt_q == LAST)) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign filt_d = ((clk_s != filt_q) && (cnt_q == LAST)) ? clk_s : filt_q;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         filt_q <= 1'b1;
         fall_q <= 1'b0;
      end else begin
         filt_q <= filt_d;
         fall_q <= filt_q & ~filt_d;
      end
   end

   assign clk_filt_o = filt_q;
   assign dat_sync_o = dat_sync_q[SYNC_STAGES-1];
   assign fall_o     = fall_q;

   AST_FALL_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (rst_i)
      fall_o |=> !fall_o); // R6
endmodule

// File: rtl/ps2h_stall.sv
module ps2h_stall #(
   parameter int unsigned LIMIT = 100000
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic active_i,
   input  logic kick_i,
   output logic expire_o
);
   localparam int unsigned CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i || !active_i || kick_i) begin
         cnt_q <= '0;
      end else if (cnt_q != LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = active_i && (cnt_q == LAST);

   AST_STALL_ABORTS: assert property (@(posedge clk_i) disable iff (rst_i)
      expire_o |=> !expire_o); // R10
endmodule

// File: rtl/ps2h_rx.sv
module ps2h_rx
   import ps2h_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_i,
   input  logic  en_i,
   input  logic  fall_i,
   input  logic  dat_i,
   input  logic  abort_i,
   output logic  busy_o,
   output logic  valid_o,
   output byte_t byte_o
);
   localparam int unsigned CW = $clog2(FRAME_W);
   localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

   rx_state_e          st_q;
   logic [CW-1:0]      cnt_q;
   logic [FRAME_W-1:0] sh_q;
   logic [FRAME_W-1:0] sh_nx;
   logic               frame_ok;
   logic               valid_q;
   byte_t              byte_q;

   assign sh_nx    = {dat_i, sh_q[FRAME_W-1:1]};
   assign frame_ok = (^sh_nx[BYTE_W:0]) & sh_nx[FRAME_W-1];

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         valid_q <= 1'b0;
         byte_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (abort_i) begin
            st_q <= RX_IDLE;
         end else begin
            case (st_q)
               RX_IDLE: begin
                  if (en_i && fall_i && !dat_i) begin
                     st_q  <= RX_FRAME;
                     cnt_q <= '0;
                  end
               end
               RX_FRAME: begin
                  if (fall_i) begin
                     sh_q <= sh_nx;
                     if (cnt_q == LAST) begin
                        st_q    <= RX_IDLE;
                        valid_q <= frame_ok;
                        byte_q  <= sh_nx[BYTE_W-1:0];
                     end else begin
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign busy_o  = (st_q == RX_FRAME);
   assign valid_o = valid_q;
   assign byte_o  = byte_q;

   AST_RX_START_GATED: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(busy_o) |-> $past(en_i)); // R3
endmodule

// File: rtl/ps2h_tx.sv
module ps2h_tx
   import ps2h_pkg::*;
#(
   parameter int unsigned INHIBIT_CYC = 5000
) (
   input  logic  clk_i,
   input  logic  rst_i,
   input  logic  start_i,
   input  byte_t byte_i,
   input  logic  fall_i,
   input  logic  abort_i,
   output logic  busy_o,
   output logic  wait_dev_o,
   output logic  clk_oe_o,
   output logic  dat_oe_o
);
   localparam int unsigned IW = $clog2(INHIBIT_CYC + 1);
   localparam logic [IW-1:0] INH_LAST = IW'(INHIBIT_CYC - 1);
   localparam int unsigned BW = $clog2(FRAME_W);
   localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);

   tx_state_e          st_q;
   logic [IW-1:0]      inh_q;
   logic [BW-1:0]      bit_q;
   logic [FRAME_W-1:0] sh_q;
   logic               clk_oe_q;
   logic               dat_oe_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         st_q     <= TX_IDLE;
         inh_q    <= '0;
         bit_q    <= '0;
         sh_q     <= '0;
         clk_oe_q <= 1'b0;
         dat_oe_q <= 1'b0;
      end else if (abort_i) begin
         st_q     <= TX_IDLE;
         clk_oe_q <= 1'b0;
         dat_oe_q <= 1'b0;
      end else begin
         case (st_q)
            TX_IDLE: begin
               if (start_i) begin
                  sh_q     <= {1'b1, odd_fill(byte_i), byte_i};
                  inh_q    <= '0;
                  clk_oe_q <= 1'b1;
                  st_q     <= TX_INHIBIT;
               end
            end
            TX_INHIBIT: begin
               if (inh_q == INH_LAST) begin
                  dat_oe_q <= 1'b1;
                  st_q     <= TX_RELEASE;
               end else begin
                  inh_q <= inh_q + 1'b1;
               end
            end
            TX_RELEASE: begin
               clk_oe_q <= 1'b0;
               bit_q    <= '0;
               st_q     <= TX_BITS;
            end
            TX_BITS: begin
               if (fall_i) begin
                  dat_oe_q <= ~sh_q[0];
                  sh_q     <= {1'b1, sh_q[FRAME_W-1:1]};
                  if (bit_q == BIT_LAST) begin
                     st_q <= TX_ACK;
                  end else begin
                     bit_q <= bit_q + 1'b1;
                  end
               end
            end
            TX_ACK: begin
               if (fall_i) begin
                  dat_oe_q <= 1'b0;
                  st_q     <= TX_IDLE;
               end
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign busy_o     = (st_q != TX_IDLE);
   assign wait_dev_o = (st_q == TX_RELEASE) || (st_q == TX_BITS) || (st_q == TX_ACK);
   assign clk_oe_o   = clk_oe_q;
   assign dat_oe_o   = dat_oe_q;

   AST_TX_NEEDS_START: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(clk_oe_o) |-> $past(start_i)); // R1
   AST_TX_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (rst_i)
      !busy_o |-> (!clk_oe_o && !dat_oe_o)); // R10
endmodule

// File: rtl/ps2h_top.sv
module ps2h_top
   import ps2h_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 4,
   parameter int unsigned INHIBIT_CYC = 5000,
   parameter int unsigned TIMEOUT_CYC = 100000,
   parameter int unsigned IRQ_HOLD    = 16
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wb_cyc_i,
   input  logic              wb_stb_i,
   input  logic              wb_we_i,
   input  logic              wb_adr_i,
   input  logic [BYTE_W-1:0] wb_dat_i,
   output logic [BYTE_W-1:0] wb_dat_o,
   output logic              wb_ack_o,
   output logic              irq_o,
   input  logic              ps2_clk_i,
   output logic              ps2_clk_oe_o,
   input  logic              ps2_dat_i,
   output logic              ps2_dat_oe_o
);
   localparam int unsigned QW = $clog2(IRQ_HOLD + 1);
   localparam logic [QW-1:0] IRQ_LOAD = QW'(IRQ_HOLD);
   localparam int unsigned STROBE_BIT = 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (IRQ_HOLD < IRQ_MIN) begin : g_bad_irq
         $error("IRQ_HOLD below the minimum interrupt width");
      end
      if (INHIBIT_CYC <= SYNC_STAGES + FILT_LEN + 2) begin : g_bad_inh
         $error("INHIBIT_CYC must exceed the clock filter latency");
      end
      if (TIMEOUT_CYC < 2) begin : g_bad_to
         $error("TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   logic    clk_filt, dat_sync, fall;
   logic    rx_busy, rx_valid, rx_abort, rx_en;
   byte_t   rx_byte;
   logic    tx_busy, tx_wait, tx_abort, tx_start;
   byte_t   tx_buf_q;
   byte_t   rx_reg_q;
   logic    strobe_q;
   logic    ack_q;
   byte_t   rd_q;
   logic    busy;
   logic    hit, wr;
   logic [QW-1:0] irq_cnt_q;

   ps2h_line_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
   ) u_filter (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .line_clk_i (ps2_clk_i),
      .line_dat_i (ps2_dat_i),
      .clk_filt_o (clk_filt),
      .dat_sync_o (dat_sync),
      .fall_o     (fall)
   );

   ps2h_rx u_rx (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .en_i    (rx_en),
      .fall_i  (fall),
      .dat_i   (dat_sync),
      .abort_i (rx_abort),
      .busy_o  (rx_busy),
      .valid_o (rx_valid),
      .byte_o  (rx_byte)
   );

   ps2h_tx #(
      .INHIBIT_CYC (INHIBIT_CYC)
   ) u_tx (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .start_i    (tx_start),
      .byte_i     (tx_buf_q),
      .fall_i     (fall),
      .abort_i    (tx_abort),
      .busy_o     (tx_busy),
      .wait_dev_o (tx_wait),
      .clk_oe_o   (ps2_clk_oe_o),
      .dat_oe_o   (ps2_dat_oe_o)
   );

   ps2h_stall #(.LIMIT(TIMEOUT_CYC)) u_rx_stall (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .active_i (rx_busy),
      .kick_i   (fall),
      .expire_o (rx_abort)
   );

   ps2h_stall #(.LIMIT(TIMEOUT_CYC)) u_tx_stall (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .active_i (tx_wait),
      .kick_i   (fall),
      .expire_o (tx_abort)
   );

   assign hit      = wb_cyc_i && wb_stb_i && !ack_q;
   assign wr       = hit && wb_we_i;
   assign tx_start = strobe_q && !tx_busy && !rx_busy;
   assign rx_en    = !tx_busy && !tx_start;
   assign busy     = strobe_q || tx_busy || rx_busy;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ack_q     <= 1'b0;
         rd_q      <= '0;
         tx_buf_q  <= '0;
         rx_reg_q  <= '0;
         strobe_q  <= 1'b0;
         irq_cnt_q <= '0;
      end else begin
         ack_q <= hit;
         if (hit) begin
            rd_q <= wb_adr_i ? {{(BYTE_W-2){1'b0}}, strobe_q, busy} : rx_reg_q;
         end
         if (wr && !wb_adr_i) begin
            tx_buf_q <= wb_dat_i;
         end
         if (tx_start) begin
            strobe_q <= 1'b0;
         end else if (wr && wb_adr_i && wb_dat_i[STROBE_BIT]) begin
            strobe_q <= 1'b1;
         end
         if (rx_valid) begin
            rx_reg_q  <= rx_byte;
            irq_cnt_q <= IRQ_LOAD;
         end else if (irq_cnt_q != '0) begin
            irq_cnt_q <= irq_cnt_q - 1'b1;
         end
      end
   end

   assign wb_ack_o = ack_q;
   assign wb_dat_o = rd_q;
   assign irq_o    = (irq_cnt_q != '0);

   // width of the current interrupt pulse, for the minimum-width check
   logic [7:0] irq_age_q;
   always_ff @(posedge clk_i) begin
      if (rst_i || !irq_o) begin
         irq_age_q <= '0;
      end else if (irq_age_q != 8'hFF) begin
         irq_age_q <= irq_age_q + 1'b1;
      end
   end

   AST_IRQ_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(irq_o) |-> (irq_age_q >= 8'(IRQ_MIN))); // R9
   AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (rst_i)
      !(tx_busy && rx_busy)); // R3
   AST_STROBE_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(tx_busy) |-> !strobe_q); // R2
   AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      wb_ack_o |=> !wb_ack_o); // R12
   AST_FILTER_FALL_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      fall |-> !clk_filt); // R6
endmodule

// File: tb/tb_ps2h_top.sv
`timescale 1ns/1ps
module tb_ps2h_top;
   localparam int INH  = 60;
   localparam int TOUT = 400;
   localparam int HOLD = 16;
   localparam int H    = 25;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic       cyc = 0, stb = 0, we = 0, adr = 0;
   logic [7:0] wdat = 0;
   logic [7:0] rdat;
   logic       ack, irq, clk_oe, dat_oe;
   logic       dev_clk = 1, dev_dat = 1;
   wire        clk_line = dev_clk & ~clk_oe;
   wire        dat_line = dev_dat & ~dat_oe;

   ps2h_top #(
      .SYNC_STAGES (2),
      .FILT_LEN    (4),
      .INHIBIT_CYC (INH),
      .TIMEOUT_CYC (TOUT),
      .IRQ_HOLD    (HOLD)
   ) dut (
      .clk_i        (clk),
      .rst_i        (rst),
      .wb_cyc_i     (cyc),
      .wb_stb_i     (stb),
      .wb_we_i      (we),
      .wb_adr_i     (adr),
      .wb_dat_i     (wdat),
      .wb_dat_o     (rdat),
      .wb_ack_o     (ack),
      .irq_o        (irq),
      .ps2_clk_i    (clk_line),
      .ps2_clk_oe_o (clk_oe),
      .ps2_dat_i    (dat_line),
      .ps2_dat_oe_o (dat_oe)
   );

   int n_chk = 0;
   int n_fail = 0;

   // interrupt monitor: counts rising edges and the width of the last pulse
   int   irq_rises = 0;
   int   irq_run = 0;
   int   irq_len = 0;
   logic irq_prev = 0;
   always @(negedge clk) begin
      if (irq && !irq_prev) irq_rises <= irq_rises + 1;
      if (irq) irq_run <= irq_run + 1;
      else if (irq_run != 0) begin
         irq_len <= irq_run;
         irq_run <= 0;
      end
      irq_prev <= irq;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wb_xfer(input logic w, input logic a, input logic [7:0] d, output logic [7:0] r);
      @(negedge clk);
      cyc = 1; stb = 1; we = w; adr = a; wdat = d;
      do @(negedge clk); while (!ack);
      r = rdat;
      cyc = 0; stb = 0; we = 0;
   endtask

   task automatic wb_wr(input logic a, input logic [7:0] d);
      logic [7:0] r;
      wb_xfer(1'b1, a, d, r);
   endtask

   task automatic wb_rd(input logic a, output logic [7:0] r);
      wb_xfer(1'b0, a, 8'h00, r);
   endtask

   // device sends a frame; bad flips the parity bit
   task automatic dev_send(input logic [7:0] b, input bit bad);
      logic [10:0] fr;
      fr = {1'b1, (~^b) ^ bad, b, 1'b0};
      for (int i = 0; i < 11; i++) begin
         @(negedge clk) dev_dat = fr[i];
         wait_n(H);
         dev_clk = 0;
         wait_n(H);
         dev_clk = 1;
      end
      @(negedge clk) dev_dat = 1;
   endtask

   // device receives a host frame: reports inhibit width, start level and bits
   task automatic dev_recv(output logic [9:0] bits, output int inh, output logic start_low);
      inh = 0;
      while (clk_line) @(negedge clk);
      while (!clk_line) begin
         @(negedge clk);
         inh++;
      end
      start_low = !dat_line;
      for (int k = 0; k < 10; k++) begin
         wait_n(H);
         dev_clk = 0;
         wait_n(H);
         dev_clk = 1;
         bits[k] = dat_line;
      end
      wait_n(H / 2);
      dev_dat = 0;
      wait_n(H / 2);
      dev_clk = 0;
      wait_n(H);
      dev_clk = 1;
      dev_dat = 1;
   endtask

   // [9] 1 = host transmits, [8] 1 = device sends wrong parity, [7:0] byte
   localparam logic [9:0] VEC [8] = '{
      {2'b00, 8'hA5}, {2'b00, 8'h00}, {2'b01, 8'hFF}, {2'b00, 8'h81},
      {2'b01, 8'h3C}, {2'b10, 8'h5A}, {2'b10, 8'hED}, {2'b10, 8'h01}
   };

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the run ended");
      summary();
      $finish;
   end

   initial begin : main
      logic [7:0] r;
      logic [9:0] bits;
      int         inh;
      logic       st_low;
      logic [7:0] exp_data;
      int         r0;

      wait_n(5);
      rst = 0;
      wait_n(3);

      // R11 reset state
      chk(irq == 0, "R11 irq after reset", irq, 0);
      chk(clk_oe == 0 && dat_oe == 0, "R11 enables after reset", {clk_oe, dat_oe}, 0);
      wb_rd(1'b1, r);
      chk(r == 8'h00, "R11 control after reset", r, 0);
      wb_rd(1'b0, r);
      chk(r == 8'h00, "R11 data after reset", r, 0);
      @(negedge clk);
      chk(ack == 0, "R12 ack lasts one cycle", ack, 0);
      exp_data = 8'h00;

      // vector table
      foreach (VEC[i]) begin
         if (VEC[i][9] == 1'b0) begin
            r0 = irq_rises;
            dev_send(VEC[i][7:0], VEC[i][8]);
            wait_n(60);
            if (!VEC[i][8]) begin
               exp_data = VEC[i][7:0];
               chk(irq_rises == r0 + 1, "R7 interrupt on good frame", irq_rises - r0, 1);
               chk(irq_len >= 13 && irq_len == HOLD, "R9 interrupt width", irq_len, HOLD);
            end else begin
               chk(irq_rises == r0, "R8 no interrupt on bad parity", irq_rises - r0, 0);
            end
            wb_rd(1'b0, r);
            chk(r == exp_data, VEC[i][8] ? "R8 data kept" : "R6 R7 received byte", r, exp_data);
         end else begin
            wb_wr(1'b0, VEC[i][7:0]);
            wb_wr(1'b1, 8'h02);
            dev_recv(bits, inh, st_low);
            chk(inh >= INH - 2, "R4 inhibit width", inh, INH);
            chk(st_low, "R4 start bit low at release", st_low, 1);
            chk(bits[7:0] == VEC[i][7:0], "R5 transmitted byte", bits[7:0], VEC[i][7:0]);
            chk(^bits[8:0] == 1'b1, "R5 odd parity", bits[8], ~^VEC[i][7:0]);
            chk(bits[9] == 1'b1, "R5 stop bit", bits[9], 1);
            wait_n(20);
            wb_rd(1'b1, r);
            chk(r == 8'h00, "R3 busy clear after frame", r, 0);
         end
      end

      // R1 staging without strobe
      wb_wr(1'b0, 8'h12);
      wait_n(INH * 3);
      chk(clk_oe == 0 && dat_oe == 0, "R1 no drive without strobe", {clk_oe, dat_oe}, 0);
      wb_rd(1'b1, r);
      chk(r == 8'h00, "R1 control idle without strobe", r, 0);

      // R3 busy during reception
      fork
         dev_send(8'h66, 1'b0);
         begin
            wait_n(200);
            wb_rd(1'b1, r);
            chk(r[0] == 1'b1, "R3 busy during reception", r[0], 1);
         end
      join
      wait_n(60);

      // R2 strobe waits behind a reception, then transmits
      fork
         begin
            dev_send(8'h3C, 1'b0);
            dev_recv(bits, inh, st_low);
         end
         begin
            wait_n(200);
            wb_wr(1'b0, 8'h77);
            wb_wr(1'b1, 8'h02);
            wb_rd(1'b1, r);
            chk(r == 8'h03, "R2 strobe pending during reception", r, 8'h03);
         end
      join
      chk(bits[7:0] == 8'h77, "R2 deferred byte sent", bits[7:0], 8'h77);
      wait_n(20);
      wb_rd(1'b0, r);
      chk(r == 8'h3C, "R7 byte before deferred send", r, 8'h3C);
      wb_rd(1'b1, r);
      chk(r == 8'h00, "R2 strobe cleared after start", r, 0);

      // R10 transmit with a silent device
      wb_wr(1'b0, 8'hC3);
      wb_wr(1'b1, 8'h02);
      wait_n(INH / 2);
      chk(clk_oe == 1, "R4 clock held low while inhibiting", clk_oe, 1);
      wait_n(INH + TOUT + 60);
      wb_rd(1'b1, r);
      chk(r == 8'h00, "R10 busy clears after transmit stall", r, 0);
      chk(clk_oe == 0 && dat_oe == 0, "R10 wires released", {clk_oe, dat_oe}, 0);

      // R10 reception stalls after three bits
      @(negedge clk) dev_dat = 0;
      for (int k = 0; k < 4; k++) begin
         wait_n(H);
         dev_clk = 0;
         wait_n(H);
         dev_clk = 1;
         dev_dat = k[0];
      end
      dev_dat = 1;
      wait_n(20);
      wb_rd(1'b1, r);
      chk(r[0] == 1'b1, "R10 busy in stalled frame", r[0], 1);
      wait_n(TOUT + 60);
      wb_rd(1'b1, r);
      chk(r == 8'h00, "R10 busy clears after receive stall", r, 0);
      r0 = irq_rises;
      dev_send(8'h5E, 1'b0);
      wait_n(60);
      wb_rd(1'b0, r);
      chk(r == 8'h5E, "R10 frame after stall received", r, 8'h5E);
      chk(irq_rises == r0 + 1, "R10 interrupt after stall", irq_rises - r0, 1);

      summary();
      $finish;
   end
endmodule